// File: doc/BRIEF.md
# Pin Event Detector

This block watches one port of 32 input pins. Each pin carries a 4-bit event code that chooses how its synchronized input is turned into events: a status flag with a DMA request, a status flag alone, a level- or edge-sensitive interrupt, or a trigger output that follows the pin directly. The status flags sit in one 32-bit vector in which bit n belongs to pin n. Software clears a flag by writing a 1 to its bit. A flag raised for DMA also clears when the DMA engine reports that the transfer is done.

Event codes are loaded for many pins at once through two group-write strobes, one for pins 0 to 15 and one for pins 16 to 31. Both strobes share one 32-bit data word. The port's combined interrupt line and its combined DMA request line are ORs over the flags of pins whose codes belong to each class.

Top module: `pin_evt_ctrl`

## Requirements
- R1: After reset, every flag, `irq_o`, `dma_req_o` and every `trig_o` bit is 0, and every pin's code is 0.
- R2: Code 0 and the reserved codes 4 and 0xF never set a flag, never take part in `irq_o` or `dma_req_o`, and never drive `trig_o`.
- R3: Code 1 sets the pin's flag on a rising edge, code 2 on a falling edge and code 3 on either edge. `dma_req_o` is 1 exactly when some flag is set whose pin holds a code from 1 to 3.
- R4: Codes 5, 6 and 7 set the flag on a rising, falling or either edge respectively. They contribute to neither `irq_o` nor `dma_req_o`.
- R5: Code 9 sets the flag on a rising edge, 0xA on a falling edge and 0xB on either edge. `irq_o` is 1 exactly when some flag is set whose pin holds a code from 8 to 0xC.
- R6: Code 8 sets the flag while the synchronized pin is 0, and code 0xC while it is 1. If such a flag is cleared while its level is still present, it reads 0 for one cycle and 1 on the next.
- R7: With code 0xD, `trig_o[n]` follows the synchronized pin. With code 0xE, it follows the inverted pin. Neither code sets a flag.
- R8: A cycle with `flag_wr`=1 clears every flag n for which `flag_wdata[n]`=1. Bits written as 0 leave their flags unchanged.
- R9: A pulse on `dma_done_i[n]` clears flag n only when pin n holds a code from 1 to 3. It has no effect on flags under any other code.
- R10: With `cfg_we_lo`=1, each pin p in 0 to 15 whose mask bit `cfg_wdata[p]` is 1 takes code `cfg_wdata[19:16]`. With `cfg_we_hi`=1, each pin 16+p whose mask bit `cfg_wdata[p]` is 1 takes that code. Pins whose mask bit is 0 keep their code.
- R11: Changing a pin's code while the pin is steady never creates an edge event.
- R12: A pin change made before clock edge E1 appears in `flag_o` and `trig_o` after the third rising edge, counting E1. `irq_o` and `dma_req_o` follow one edge after the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| cfg_we_lo | input | 1 | Group code write for pins 0 to 15 |
| cfg_we_hi | input | 1 | Group code write for pins 16 to 31 |
| cfg_wdata | input | 32 | Code in bits 19:16, pin mask in bits 15:0 |
| flag_wr | input | 1 | Write strobe for clearing flags |
| flag_wdata | input | 32 | Clear mask: a 1 clears that pin's flag |
| dma_done_i | input | 32 | Per-pin transfer-complete pulse |
| flag_o | output | 32 | Status flags, bit n for pin n |
| irq_o | output | 1 | Combined port interrupt |
| dma_req_o | output | 1 | Combined DMA request |
| trig_o | output | 32 | Per-pin trigger outputs |

## Verification
A corrupted event code appears at the ports three edges after the next pin change. The pin's flag then either fails to rise or rises for the wrong edge polarity, and its contribution to `irq_o` or `dma_req_o` goes wrong one edge later. A code that should select a trigger is seen at once on `trig_o`. A stale or inverted previous-value register shows up as a flag raised by a configuration write or by the first edge after it. A wrong clear path shows up in the cycle after a write: a flag that stays set, a neighbouring flag that drops, or a level flag that fails to come back one cycle later.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [3:0] {
    EV_OFF   = 4'h0,
    DMA_RISE = 4'h1,
    DMA_FALL = 4'h2,
    DMA_BOTH = 4'h3,
    EV_RSV4  = 4'h4,
    FLG_RISE = 4'h5,
    FLG_FALL = 4'h6,
    FLG_BOTH = 4'h7,
    IRQ_LOW  = 4'h8,
    IRQ_RISE = 4'h9,
    IRQ_FALL = 4'hA,
    IRQ_BOTH = 4'hB,
    IRQ_HIGH = 4'hC,
    TRG_HIGH = 4'hD,
    TRG_LOW  = 4'hE,
    EV_RSVF  = 4'hF
  } evt_code_e;

  localparam int CODE_W = 4;

  function automatic logic code_is_dma(input logic [3:0] c);
    return (c >= 4'h1) && (c <= 4'h3);
  endfunction

  function automatic logic code_is_irq(input logic [3:0] c);
    return (c >= 4'h8) && (c <= 4'hC);
  endfunction

  function automatic logic code_is_trig(input logic [3:0] c);
    return (c == 4'hD) || (c == 4'hE);
  endfunction

  function automatic logic code_can_flag(input logic [3:0] c);
    return (c != 4'h0) && (c != 4'h4) && (c < 4'hD);
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int NPIN   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] prv_o
);
  logic [NPIN-1:0] chain_q [STAGES];
  logic [NPIN-1:0] prv_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= pin_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  // previous synchronized value always tracks, independent of any code
  always_ff @(posedge clk) begin
    if (rst) prv_q <= '0;
    else     prv_q <= chain_q[STAGES-1];
  end

  assign lvl_o = chain_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import pin_evt_pkg::*;
#(
  parameter int NPIN     = 32,
  parameter int DATA_W   = 32,
  parameter int CODE_LSB = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_lo,
  input  logic                         we_hi,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NPIN-1:0][CODE_W-1:0]  code_o
);
  localparam int HALF = NPIN / 2;

  logic [CODE_W-1:0] new_code;
  assign new_code = wdata[CODE_LSB +: CODE_W];

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    localparam int IDX = g % HALF;
    logic sel;
    if (g < HALF) begin : g_lo
      assign sel = we_lo && wdata[IDX];
    end else begin : g_hi
      assign sel = we_hi && wdata[IDX];
    end
    always_ff @(posedge clk) begin
      if (rst)      code_o[g] <= '0;
      else if (sel) code_o[g] <= new_code;
    end
  end
endmodule

// File: rtl/evt_detect.sv
module evt_detect
  import pin_evt_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0]              lvl,
  input  logic [NPIN-1:0]              prv,
  input  logic [NPIN-1:0][CODE_W-1:0]  code,
  output logic [NPIN-1:0]              edge_hit,
  output logic [NPIN-1:0]              level_hit,
  output logic [NPIN-1:0]              dma_pin,
  output logic [NPIN-1:0]              irq_pin,
  output logic [NPIN-1:0]              trig_d
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic rise, fall;
    assign rise = lvl[g] & ~prv[g];
    assign fall = ~lvl[g] & prv[g];

    always_comb begin
      edge_hit[g]  = 1'b0;
      level_hit[g] = 1'b0;
      trig_d[g]    = 1'b0;
      case (evt_code_e'(code[g]))
        DMA_RISE, FLG_RISE, IRQ_RISE: edge_hit[g] = rise;
        DMA_FALL, FLG_FALL, IRQ_FALL: edge_hit[g] = fall;
        DMA_BOTH, FLG_BOTH, IRQ_BOTH: edge_hit[g] = rise | fall;
        IRQ_LOW:                      level_hit[g] = ~lvl[g];
        IRQ_HIGH:                     level_hit[g] = lvl[g];
        TRG_HIGH:                     trig_d[g] = lvl[g];
        TRG_LOW:                      trig_d[g] = ~lvl[g];
        default: ;
      endcase
    end

    assign dma_pin[g] = code_is_dma(code[g]);
    assign irq_pin[g] = code_is_irq(code[g]);
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] edge_hit,
  input  logic [NPIN-1:0] level_hit,
  input  logic [NPIN-1:0] dma_pin,
  input  logic [NPIN-1:0] irq_pin,
  input  logic            wr,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] dma_done,
  output logic [NPIN-1:0] flag_o,
  output logic            irq_o,
  output logic            dma_req_o
);
  logic [NPIN-1:0] sw_clr, clr, flag_d, flag_q;
  logic            irq_q, dma_q;

  assign sw_clr = wr ? wdata : '0;
  assign clr    = sw_clr | (dma_done & dma_pin);
  // a new edge wins over a clear; a held level returns one cycle after its clear
  assign flag_d = (flag_q & ~clr) | edge_hit | (level_hit & ~sw_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |(flag_q & irq_pin);
      dma_q  <= |(flag_q & dma_pin);
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign dma_req_o = dma_q;
endmodule

// File: rtl/pin_evt_ctrl.sv
module pin_evt_ctrl
  import pin_evt_pkg::*;
#(
  parameter int NPIN     = 32,
  parameter int DATA_W   = 32,
  parameter int CODE_LSB = 16,
  parameter int STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              cfg_we_lo,
  input  logic              cfg_we_hi,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              flag_wr,
  input  logic [NPIN-1:0]   flag_wdata,
  input  logic [NPIN-1:0]   dma_done_i,
  output logic [NPIN-1:0]   flag_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic [NPIN-1:0]   trig_o
);
  logic [NPIN-1:0]             lvl, prv;
  logic [NPIN-1:0][CODE_W-1:0] code_q;
  logic [NPIN-1:0]             edge_hit, level_hit, dma_pin, irq_pin, trig_d;
  logic [NPIN-1:0]             trig_q;

  pin_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .lvl_o(lvl), .prv_o(prv)
  );

  cfg_bank #(.NPIN(NPIN), .DATA_W(DATA_W), .CODE_LSB(CODE_LSB)) u_cfg (
    .clk(clk), .rst(rst), .we_lo(cfg_we_lo), .we_hi(cfg_we_hi),
    .wdata(cfg_wdata), .code_o(code_q)
  );

  evt_detect #(.NPIN(NPIN)) u_det (
    .lvl(lvl), .prv(prv), .code(code_q), .edge_hit(edge_hit),
    .level_hit(level_hit), .dma_pin(dma_pin), .irq_pin(irq_pin), .trig_d(trig_d)
  );

  flag_bank #(.NPIN(NPIN)) u_flag (
    .clk(clk), .rst(rst), .edge_hit(edge_hit), .level_hit(level_hit),
    .dma_pin(dma_pin), .irq_pin(irq_pin), .wr(flag_wr), .wdata(flag_wdata),
    .dma_done(dma_done_i), .flag_o(flag_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_q <= '0;
    else     trig_q <= trig_d;
  end
  assign trig_o = trig_q;
endmodule

// File: rtl/pin_evt_chk.sv
module pin_evt_chk
  import pin_evt_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPIN-1:0]              flag_o,
  input logic                         irq_o,
  input logic                         dma_req_o,
  input logic [NPIN-1:0]              trig_o,
  input logic                         flag_wr,
  input logic [NPIN-1:0]              flag_wdata,
  input logic [NPIN-1:0]              dma_done_i,
  input logic [NPIN-1:0][CODE_W-1:0]  code_q
);
  logic [NPIN-1:0] irq_m, dma_m;
  for (genvar i = 0; i < NPIN; i++) begin : g_m
    assign irq_m[i] = code_is_irq(code_q[i]);
    assign dma_m[i] = code_is_dma(code_q[i]);
  end

  // R5: combined interrupt follows the previous cycle's interrupt-class flags
  a_r5_irq_combine: assert property (@(posedge clk) disable iff (rst)
    irq_o == |($past(flag_o) & $past(irq_m)));

  // R3: combined DMA request follows the previous cycle's DMA-class flags
  a_r3_dma_combine: assert property (@(posedge clk) disable iff (rst)
    dma_req_o == |($past(flag_o) & $past(dma_m)));

  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    // R8: a flag only drops after a written 1 or a DMA completion on a DMA pin (R9)
    a_r8_clear_source: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_o[i]) |-> $past((flag_wr && flag_wdata[i]) ||
                                 (dma_done_i[i] && code_is_dma(code_q[i]))));
    // R2: a flag can only rise under a flag-producing code
    a_r2_rise_code: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_o[i]) |-> $past(code_can_flag(code_q[i])));
    // R7: trigger outputs only under trigger codes
    a_r7_trig_code: assert property (@(posedge clk) disable iff (rst)
      trig_o[i] |-> $past(code_is_trig(code_q[i])));
  end
endmodule

bind pin_evt_ctrl pin_evt_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .flag_o(flag_o), .irq_o(irq_o), .dma_req_o(dma_req_o),
  .trig_o(trig_o), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .dma_done_i(dma_done_i), .code_q(code_q)
);

// File: tb/tb_pin_evt_ctrl.sv
`timescale 1ns/1ps
module tb_pin_evt_ctrl;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  pin_i;
  logic          cfg_we_lo, cfg_we_hi;
  logic [31:0]   cfg_wdata;
  logic          flag_wr;
  logic [N-1:0]  flag_wdata, dma_done_i;
  logic [N-1:0]  flag_o, trig_o;
  logic          irq_o, dma_req_o;

  int tests = 0;
  int fails = 0;

  logic [3:0]   m_code [N];
  logic [N-1:0] m_pins;
  logic [N-1:0] m_flag;

  always #5 clk = ~clk;

  pin_evt_ctrl dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi),
    .cfg_wdata(cfg_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .dma_done_i(dma_done_i), .flag_o(flag_o), .irq_o(irq_o), .dma_req_o(dma_req_o),
    .trig_o(trig_o)
  );

  function automatic bit f_rise(input logic [3:0] c);
    return c inside {4'h1, 4'h3, 4'h5, 4'h7, 4'h9, 4'hB};
  endfunction
  function automatic bit f_fall(input logic [3:0] c);
    return c inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB};
  endfunction
  function automatic bit f_lvl(input logic [3:0] c, input bit p);
    return (c == 4'h8 && !p) || (c == 4'hC && p);
  endfunction

  function automatic logic [N-1:0] lvl_mask();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = f_lvl(m_code[i], m_pins[i]);
    return m;
  endfunction
  function automatic logic [N-1:0] trig_exp();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++)
      m[i] = (m_code[i] == 4'hD) ? m_pins[i] : (m_code[i] == 4'hE) ? !m_pins[i] : 1'b0;
    return m;
  endfunction
  function automatic bit irq_exp();
    bit r = 0;
    for (int i = 0; i < N; i++) if (m_flag[i] && m_code[i] >= 4'h8 && m_code[i] <= 4'hC) r = 1;
    return r;
  endfunction
  function automatic bit dma_exp();
    bit r = 0;
    for (int i = 0; i < N; i++) if (m_flag[i] && m_code[i] >= 4'h1 && m_code[i] <= 4'h3) r = 1;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input bit hi, input logic [3:0] code, input logic [15:0] mask);
    cfg_we_lo = !hi; cfg_we_hi = hi;
    cfg_wdata = {12'h0, code, mask};
    @(negedge clk);
    cfg_we_lo = 0; cfg_we_hi = 0; cfg_wdata = '0;
    for (int p = 0; p < 16; p++) if (mask[p]) m_code[hi ? p + 16 : p] = code;
    settle(4);
    m_flag |= lvl_mask();
  endtask

  task automatic drive_pins(input logic [N-1:0] np);
    pin_i = np;
    for (int i = 0; i < N; i++) begin
      if (!m_pins[i] && np[i] && f_rise(m_code[i])) m_flag[i] = 1'b1;
      if (m_pins[i] && !np[i] && f_fall(m_code[i])) m_flag[i] = 1'b1;
    end
    m_pins = np;
    settle(6);
    m_flag |= lvl_mask();
  endtask

  task automatic clear_flags(input logic [N-1:0] m);
    flag_wr = 1; flag_wdata = m;
    @(negedge clk);
    flag_wr = 0; flag_wdata = '0;
    m_flag &= ~m;
    settle(3);
    m_flag |= lvl_mask();
  endtask

  task automatic dma_pulse(input logic [N-1:0] m);
    dma_done_i = m;
    @(negedge clk);
    dma_done_i = '0;
    for (int i = 0; i < N; i++)
      if (m[i] && m_code[i] >= 4'h1 && m_code[i] <= 4'h3) m_flag[i] = 1'b0;
    settle(3);
    m_flag |= lvl_mask();
  endtask

  task automatic check_all(input string req);
    check({req, " flags"}, 64'(flag_o), 64'(m_flag));
    check({req, " irq"},   64'(irq_o), 64'(irq_exp()));
    check({req, " dma"},   64'(dma_req_o), 64'(dma_exp()));
    check({req, " trig"},  64'(trig_o), 64'(trig_exp()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; pin_i = '0; cfg_we_lo = 0; cfg_we_hi = 0; cfg_wdata = '0;
    flag_wr = 0; flag_wdata = '0; dma_done_i = '0;
    m_pins = '0; m_flag = '0;
    for (int i = 0; i < N; i++) m_code[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    settle(2);
    check_all("R1 reset");

    // R12 latency with code 9 on pin 0 (R10 low group write)
    cfg_write(0, 4'h9, 16'h0001);
    pin_i[0] = 1'b1; m_pins[0] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R12 flag not before third edge", 64'(flag_o[0]), 64'd0);
    @(posedge clk); @(negedge clk);
    check("R12 flag at third edge", 64'(flag_o[0]), 64'd1);
    check("R12 irq lags flag", 64'(irq_o), 64'd0);
    @(posedge clk); @(negedge clk);
    check("R5 irq one edge after flag", 64'(irq_o), 64'd1);
    m_flag[0] = 1'b1;
    settle(2);

    // R8: zeros do not clear, ones do
    clear_flags(~32'h1);
    check("R8 zero write keeps flag", 64'(flag_o), 64'(m_flag));
    clear_flags(32'h1);
    check("R8 one write clears flag", 64'(flag_o[0]), 64'd0);
    check("R8 irq falls", 64'(irq_o), 64'd0);

    // R6: level re-set one cycle after clear
    cfg_write(0, 4'hC, 16'h0002);
    drive_pins(m_pins | 32'h2);
    check("R6 level high sets flag", 64'(flag_o[1]), 64'd1);
    flag_wr = 1; flag_wdata = 32'h2;
    @(negedge clk);
    flag_wr = 0; flag_wdata = '0;
    check("R6 flag low the cycle after clear", 64'(flag_o[1]), 64'd0);
    @(negedge clk);
    check("R6 flag returns next cycle", 64'(flag_o[1]), 64'd1);
    settle(2);

    // R3 / R9 / R10 high group: pin 16 code 1
    cfg_write(1, 4'h1, 16'h0001);
    drive_pins(m_pins | 32'h0001_0000);
    check("R3 DMA rising flag", 64'(flag_o[16]), 64'd1);
    check("R3 dma_req_o", 64'(dma_req_o), 64'd1);
    dma_pulse(32'h0001_0002);
    check("R9 DMA pin cleared", 64'(flag_o[16]), 64'd0);
    check("R9 non-DMA pin untouched", 64'(flag_o[1]), 64'd1);
    check("R9 dma_req_o falls", 64'(dma_req_o), 64'd0);

    // R2 / R11: pin 3 high under code 0, then switched to a rising code
    drive_pins(m_pins | 32'h8);
    check("R2 code 0 no flag", 64'(flag_o[3]), 64'd0);
    cfg_write(0, 4'h9, 16'h0008);
    settle(3);
    check("R11 no spurious edge on code change", 64'(flag_o[3]), 64'd0);
    cfg_write(0, 4'hA, 16'h0008);
    drive_pins(m_pins & ~32'h8);
    check("R5 falling code sets", 64'(flag_o[3]), 64'd1);

    // R7 triggers on pins 17 and 18
    cfg_write(1, 4'hD, 16'h0002);
    cfg_write(1, 4'hE, 16'h0004);
    drive_pins(m_pins | 32'h0002_0000);
    check("R7 trigger bits", 64'(trig_o[18:17]), 64'd3);
    check("R7 no flags", 64'(flag_o[18:17]), 64'd0);
    check_all("R10 directed state");

    // random phase (R2-R10)
    for (int k = 0; k < 10; k++) begin
      logic [3:0] c;
      logic [15:0] msk;
      c = 4'($urandom_range(0, 15));
      msk = 16'($urandom);
      cfg_write(k[0], c, msk);
    end
    check_all("R10 random config");
    for (int it = 0; it < 40; it++) begin
      drive_pins(32'($urandom));
      check_all("R3 R4 R5 random edges");
      if (it % 3 == 0) begin
        clear_flags(32'($urandom));
        check_all("R8 random clear");
      end
      if (it % 4 == 1) begin
        dma_pulse(32'($urandom));
        check_all("R9 random dma done");
      end
      if (it % 8 == 7) begin
        cfg_write(it[3], 4'($urandom_range(0, 15)), 16'($urandom));
        check_all("R11 random reconfig");
      end
    end
    clear_flags('1);
    check_all("R6 final clear");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule